// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block reads from a raw 8-bit NAND flash device. A controller pulses a start input with a byte address and a mode bit. The mode selects either a full-page read or a bad-block probe. A probe fetches the single marker byte that sits in the spare area of the addressed page. The sequencer strobes out the opening command, the address cycles and, for large pages, a confirm command. It then waits for the device's ready/busy line to complete a busy-to-ready transition. After that it pulls data bytes one at a time and hands them downstream on a valid/ready stream.

The page geometry is fixed at elaboration. Small pages hold 512 bytes and use four address cycles. Large pages hold 2048 bytes and use five address cycles, a two-byte column followed by a three-byte page number. Each pin strobe lasts one clock. It is followed by a parameterised number of hold cycles, during which the bus lines stay unchanged. A one-cycle completion pulse follows the last accepted byte.

Top module: `nand_rd_seq`

## Requirements
- R1: While reset is asserted and just after it, chip enable, write strobe and read strobe are high (inactive). The command latch, address latch, bus drive, stream valid, busy and done outputs are all low.
- R2: Small-page full read: one command cycle carrying 0x00, then four address cycles carrying addr[7:0], addr[16:9], addr[24:17] and {0, addr[31:25]}, in that order.
- R3: Small-page probe: the command is 0x50. The first address byte is 0x05, which is the marker offset 517 masked to its low 4 bits. The other three address bytes match R2, and the byte returned comes from column 517.
- R4: Large-page full read: command 0x00, then five address cycles carrying 0x00, 0x00, page[7:0], page[15:8] and page[23:16], where page = addr >> 11. A confirm command of 0x30 follows.
- R5: Large-page probe: the same sequence as R4, except that the column bytes are 0x00 and then 0x08 (column 2048). The byte returned comes from column 2048.
- R6: No read strobe is issued until the ready/busy line has gone low and then high after the last command or address cycle. A high level present before the operation does not count.
- R7: A full read delivers exactly 512 (small) or 2048 (large) bytes in ascending column order. A probe delivers exactly one byte. No further byte is offered after that.
- R8: While stream valid is high and downstream ready is low, valid stays high and the data stays unchanged.
- R9: A start pulse that arrives while the block is busy is ignored. The running operation finishes with its original address and mode.
- R10: Done is high for exactly one cycle, in the cycle after the last byte is accepted. Busy is low in that cycle.
- R11: Every command or address cycle drives the write strobe low for exactly one cycle. The command latch is high only on command cycles and the address latch only on address cycles, never both at once. Both latch lines and the bus value hold through the following hold cycles.
- R12: Chip enable is low exactly while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| probe_i | input | 1 | 1 = bad-block marker probe, 0 = full page read |
| addr_i | input | ADDR_W | Flash byte address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Read byte to downstream |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Downstream accepts byte |
| nf_ce_n_o | output | 1 | Flash chip enable, active low |
| nf_cle_o | output | 1 | Flash command latch enable |
| nf_ale_o | output | 1 | Flash address latch enable |
| nf_we_n_o | output | 1 | Flash write strobe, active low |
| nf_re_n_o | output | 1 | Flash read strobe, active low |
| nf_io_o | output | 8 | Flash bus value driven out |
| nf_io_oe_o | output | 1 | Flash bus drive enable |
| nf_io_i | input | 8 | Flash bus value read in |
| nf_rb_i | input | 1 | Flash ready (1) / busy (0) |

## Verification
The bench drives two instances, one per geometry, against a behavioural flash model. The model logs every command and address byte, and it flags any read strobe made before its busy period ends. A sequencer that waited on the ready level instead of a fresh rising edge would strobe while the model is busy. Wrong bit slices, a missing 0x50 or 0x30, or a dropped column byte all show up as mismatched logged address bytes.

The probes check that exactly one marker byte from column 517 or 2048 comes back. Stalling patterns on the downstream ready expose a design that drops or changes a byte under backpressure. A start pulse injected mid-read would corrupt the data or the log if it were not ignored. The check on the final handshake catches a done pulse that is misplaced by one cycle or lasts too long.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  localparam int BUS_W = 8;

  // command opcodes
  localparam logic [BUS_W-1:0] CMD_READ    = 8'h00;
  localparam logic [BUS_W-1:0] CMD_SPARE   = 8'h50;
  localparam logic [BUS_W-1:0] CMD_CONFIRM = 8'h30;

  // geometry
  localparam int SMALL_PG_BYTES = 512;
  localparam int LARGE_PG_BYTES = 2048;
  localparam int SMALL_MARK_COL = 517;
  localparam int LARGE_MARK_COL = 2048;
  localparam int SMALL_ADDR_CYC = 4;
  localparam int LARGE_ADDR_CYC = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_CONF,
    ST_WAIT,
    ST_RD,
    ST_OUT
  } seq_st_t;

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
  import nand_rd_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b0,
  parameter int ADDR_W     = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              probe_i,
  input  logic [2:0]        idx_i,
  output logic [BUS_W-1:0]  cmd_o,
  output logic [BUS_W-1:0]  byte_o
);

  localparam int EXT_W = 40;

  logic [EXT_W-1:0] ax;
  assign ax = EXT_W'(addr_i);

  generate
    if (!LARGE_PAGE) begin : g_small
      localparam logic [BUS_W-1:0] MARK_LO = BUS_W'(SMALL_MARK_COL & 15);
      logic unused_ax;

      assign cmd_o     = probe_i ? CMD_SPARE : CMD_READ;
      assign unused_ax = ^{ax[8], ax[EXT_W-1:33]};

      always_comb begin
        case (idx_i)
          3'd0:    byte_o = probe_i ? MARK_LO : ax[7:0];
          3'd1:    byte_o = ax[16:9];
          3'd2:    byte_o = ax[24:17];
          default: byte_o = ax[32:25];
        endcase
      end
    end else begin : g_large
      localparam logic [15:0] MARK_COL = 16'(LARGE_MARK_COL);
      logic [15:0] col;
      logic        unused_ax;

      assign cmd_o     = CMD_READ;
      assign col       = probe_i ? MARK_COL : 16'd0;
      assign unused_ax = ^{ax[10:0], ax[EXT_W-1:35]};

      always_comb begin
        case (idx_i)
          3'd0:    byte_o = col[7:0];
          3'd1:    byte_o = col[15:8];
          3'd2:    byte_o = ax[18:11];
          3'd3:    byte_o = ax[26:19];
          default: byte_o = ax[34:27];
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/nand_slot_timer.sv
module nand_slot_timer #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic first_o,
  output logic end_o
);

  localparam int CNT_W = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign first_o = run_i && (cnt_q == '0);
  assign end_o   = run_i && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_en = 1'b1;
    if (!run_i || end_o) begin
      cnt_d = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nand_rdy_track.sv
module nand_rdy_track #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_i,
  input  logic clr_i,
  output logic rdy_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q, flag_d;
  logic                   rise;

  assign rise  = sync_q[SYNC_STAGES-1] && !prev_q;
  assign rdy_o = flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) begin
      flag_d = 1'b0;
    end else if (rise) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rb_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b0,
  parameter int HOLD_CYC   = 2,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              probe_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              nf_ce_n_o,
  output logic              nf_cle_o,
  output logic              nf_ale_o,
  output logic              nf_we_n_o,
  output logic              nf_re_n_o,
  output logic [BUS_W-1:0]  nf_io_o,
  output logic              nf_io_oe_o,
  input  logic [BUS_W-1:0]  nf_io_i,
  input  logic              nf_rb_i
);

  localparam int PG_BYTES = LARGE_PAGE ? LARGE_PG_BYTES : SMALL_PG_BYTES;
  localparam int BC_W     = $clog2(PG_BYTES);
  localparam int ADDR_CYC = LARGE_PAGE ? LARGE_ADDR_CYC : SMALL_ADDR_CYC;
  localparam logic [2:0]      LAST_IDX = 3'(ADDR_CYC - 1);
  localparam logic [BC_W-1:0] LAST_BC  = BC_W'(PG_BYTES - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_pipe_q[1];

  seq_st_t           st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              probe_q, probe_d;
  logic [2:0]        idx_q, idx_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [BUS_W-1:0]  data_q, data_d;
  logic              done_q, done_d;

  logic             in_wr, in_slot;
  logic             slot_first, slot_end;
  logic             rdy;
  logic [BUS_W-1:0] open_cmd, addr_byte;
  logic [BC_W-1:0]  last_bc;

  assign in_wr   = (st_q == ST_CMD) || (st_q == ST_ADDR) || (st_q == ST_CONF);
  assign in_slot = in_wr || (st_q == ST_RD);
  assign last_bc = probe_q ? '0 : LAST_BC;

  nand_addr_gen #(
    .LARGE_PAGE (LARGE_PAGE),
    .ADDR_W     (ADDR_W)
  ) addr_gen_i (
    .addr_i  (addr_q),
    .probe_i (probe_q),
    .idx_i   (idx_q),
    .cmd_o   (open_cmd),
    .byte_o  (addr_byte)
  );

  nand_slot_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) slot_tmr_i (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run_i   (in_slot),
    .first_o (slot_first),
    .end_o   (slot_end)
  );

  nand_rdy_track #(
    .SYNC_STAGES (2)
  ) rdy_trk_i (
    .clk   (clk),
    .rst_n (rst_ni),
    .rb_i  (nf_rb_i),
    .clr_i (slot_first && ((st_q == ST_CMD) || (st_q == ST_CONF))),
    .rdy_o (rdy)
  );

  // next-state logic
  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    probe_d = probe_q;
    idx_d   = idx_q;
    bc_d    = bc_q;
    data_d  = data_q;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_CMD;
          addr_d  = addr_i;
          probe_d = probe_i;
        end
      end
      ST_CMD: begin
        if (slot_end) begin
          st_d  = ST_ADDR;
          idx_d = '0;
        end
      end
      ST_ADDR: begin
        if (slot_end) begin
          if (idx_q == LAST_IDX) begin
            st_d = LARGE_PAGE ? ST_CONF : ST_WAIT;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_CONF: begin
        if (slot_end) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (rdy) begin
          st_d = ST_RD;
          bc_d = '0;
        end
      end
      ST_RD: begin
        if (slot_first) data_d = nf_io_i;
        if (slot_end)   st_d   = ST_OUT;
      end
      ST_OUT: begin
        if (rd_ready_i) begin
          if (bc_q == last_bc) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            bc_d = bc_q + 1'b1;
            st_d = ST_RD;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      probe_q <= 1'b0;
      idx_q   <= '0;
      bc_q    <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      probe_q <= probe_d;
      idx_q   <= idx_d;
      bc_q    <= bc_d;
      data_q  <= data_d;
      done_q  <= done_d;
    end
  end

  // outputs
  always_comb begin
    case (st_q)
      ST_CMD:  nf_io_o = open_cmd;
      ST_ADDR: nf_io_o = addr_byte;
      ST_CONF: nf_io_o = CMD_CONFIRM;
      default: nf_io_o = '0;
    endcase
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign rd_valid_o = (st_q == ST_OUT);
  assign rd_data_o  = data_q;
  assign nf_ce_n_o  = (st_q == ST_IDLE);
  assign nf_cle_o   = (st_q == ST_CMD) || (st_q == ST_CONF);
  assign nf_ale_o   = (st_q == ST_ADDR);
  assign nf_we_n_o  = !(in_wr && slot_first);
  assign nf_re_n_o  = !((st_q == ST_RD) && slot_first);
  assign nf_io_oe_o = in_wr;

endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk #(
  parameter int HOLD_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       done_o,
  input logic [7:0] rd_data_o,
  input logic       rd_valid_o,
  input logic       rd_ready_i,
  input logic       nf_cle_o,
  input logic       nf_ale_o,
  input logic       nf_we_n_o,
  input logic       nf_re_n_o,
  input logic [7:0] nf_io_o,
  input logic       nf_rb_i
);

  // R11
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle_o && nf_ale_o));

  generate
    if (HOLD_CYC > 0) begin : g_hold
      // R11
      wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n_o |=> nf_we_n_o && $stable(nf_io_o) && $stable(nf_cle_o) && $stable(nf_ale_o));
    end
  endgenerate

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));

  // R10
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rd_valid_o && rd_ready_i) && !busy_o);

  // R6
  read_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n_o |-> nf_rb_i);

endmodule

bind nand_rd_seq nand_rd_seq_chk #(.HOLD_CYC(HOLD_CYC)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .rd_ready_i (rd_ready_i),
  .nf_cle_o   (nf_cle_o),
  .nf_ale_o   (nf_ale_o),
  .nf_we_n_o  (nf_we_n_o),
  .nf_re_n_o  (nf_re_n_o),
  .nf_io_o    (nf_io_o),
  .nf_rb_i    (nf_rb_i)
);

// File: tb/nand_flash_model.sv
module nand_flash_model #(
  parameter bit LARGE    = 1'b0,
  parameter int BUSY_CYC = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        ce_n_i,
  input  logic        cle_i,
  input  logic        ale_i,
  input  logic        we_n_i,
  input  logic        re_n_i,
  input  logic        oe_i,
  input  logic [7:0]  io_i,
  output logic        rb_o,
  output logic [7:0]  dq_o,
  output logic [7:0]  cmd0_o,
  output logic [7:0]  cmd1_o,
  output int          ncmd_o,
  output int          nadr_o,
  output int          err_o,
  output logic [39:0] ab_o
);

  int   busy_cnt;
  int   rdcnt;
  logic armed;
  logic spare;
  int   page;
  int   col;

  function automatic logic [7:0] fdat(int pg, int cl);
    return 8'((pg * 13) + (cl * 3) + (cl >> 8));
  endfunction

  always_comb begin
    if (LARGE) begin
      page = int'(ab_o[39:16]);
      col  = int'(ab_o[15:0]) + rdcnt;
    end else begin
      page = int'(ab_o[31:8]);
      col  = (spare ? 512 + int'(ab_o[3:0]) : int'(ab_o[7:0])) + rdcnt;
    end
    dq_o = fdat(page, col);
  end

  always @(posedge clk or negedge rst_n) begin
    logic trig;
    trig = 1'b0;
    if (!rst_n) begin
      rb_o <= 1'b1; busy_cnt <= 0; rdcnt <= 0; armed <= 1'b0; spare <= 1'b0;
      cmd0_o <= '0; cmd1_o <= '0; ncmd_o <= 0; nadr_o <= 0; err_o <= 0; ab_o <= '0;
    end else if (clr_i) begin
      armed <= 1'b0; cmd0_o <= '0; cmd1_o <= '0; ncmd_o <= 0; nadr_o <= 0; err_o <= 0; ab_o <= '0;
    end else begin
      if (!we_n_i) begin
        if (ce_n_i || !oe_i || (cle_i == ale_i)) err_o <= err_o + 1;
        if (cle_i && !ale_i) begin
          if (ncmd_o == 0) cmd0_o <= io_i; else cmd1_o <= io_i;
          ncmd_o <= ncmd_o + 1;
          if (io_i == 8'h50) spare <= 1'b1;
          else if (io_i == 8'h00) spare <= 1'b0;
          if (LARGE && io_i == 8'h30) trig = 1'b1;
        end
        if (ale_i && !cle_i) begin
          if (nadr_o < 5) ab_o[8*nadr_o +: 8] <= io_i;
          nadr_o <= nadr_o + 1;
          if (!LARGE && nadr_o == 3) trig = 1'b1;
        end
      end
      if (trig) begin
        rb_o <= 1'b0; busy_cnt <= BUSY_CYC; armed <= 1'b1; rdcnt <= 0;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
        if (busy_cnt == 1) rb_o <= 1'b1;
      end
      if (!re_n_i) begin
        if (!armed || !rb_o || ce_n_i || busy_cnt > 0) err_o <= err_o + 1;
        rdcnt <= rdcnt + 1;
      end
    end
  end

endmodule

// File: tb/nand_rd_seq_tb_top.sv
module nand_rd_seq_tb_top;

  localparam int HOLD = 2;
  localparam int BUSY = 6;
  localparam int WDOG = 190000;

  // {large, probe, ready pattern[1:0], address[31:0]}
  localparam logic [35:0] VEC [0:7] = '{
    {1'b0, 1'b0, 2'd0, 32'h0000_0000},
    {1'b0, 1'b0, 2'd1, 32'hFE35_A600},
    {1'b0, 1'b1, 2'd2, 32'h0123_C000},
    {1'b1, 1'b0, 2'd0, 32'h0000_0000},
    {1'b1, 1'b0, 2'd1, 32'hABCD_E800},
    {1'b1, 1'b1, 2'd2, 32'h1F2A_0000},
    {1'b0, 1'b1, 2'd0, 32'hFFFF_FE00},
    {1'b1, 1'b0, 2'd2, 32'hFFFF_F800}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, probe, rdy, clr, geo;
  logic [31:0] addr;
  int nchk = 0, nfail = 0, cyc = 0;

  // small-geometry instance
  logic       busy_s, done_s, v_s, ce_s, cle_s, ale_s, we_s, re_s, oe_s, rb_s;
  logic [7:0] d_s, io_s, dq_s, c0_s, c1_s;
  logic [39:0] ab_s;
  int nc_s, na_s, er_s;
  // large-geometry instance
  logic       busy_l, done_l, v_l, ce_l, cle_l, ale_l, we_l, re_l, oe_l, rb_l;
  logic [7:0] d_l, io_l, dq_l, c0_l, c1_l;
  logic [39:0] ab_l;
  int nc_l, na_l, er_l;

  nand_rd_seq #(.LARGE_PAGE(1'b0), .HOLD_CYC(HOLD), .ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start & ~geo), .probe_i(probe), .addr_i(addr),
    .busy_o(busy_s), .done_o(done_s), .rd_data_o(d_s), .rd_valid_o(v_s), .rd_ready_i(rdy),
    .nf_ce_n_o(ce_s), .nf_cle_o(cle_s), .nf_ale_o(ale_s), .nf_we_n_o(we_s), .nf_re_n_o(re_s),
    .nf_io_o(io_s), .nf_io_oe_o(oe_s), .nf_io_i(dq_s), .nf_rb_i(rb_s));

  nand_flash_model #(.LARGE(1'b0), .BUSY_CYC(BUSY)) flash_s_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .ce_n_i(ce_s), .cle_i(cle_s), .ale_i(ale_s),
    .we_n_i(we_s), .re_n_i(re_s), .oe_i(oe_s), .io_i(io_s), .rb_o(rb_s), .dq_o(dq_s),
    .cmd0_o(c0_s), .cmd1_o(c1_s), .ncmd_o(nc_s), .nadr_o(na_s), .err_o(er_s), .ab_o(ab_s));

  nand_rd_seq #(.LARGE_PAGE(1'b1), .HOLD_CYC(HOLD), .ADDR_W(32)) dut_lg_i (
    .clk(clk), .rst_n(rst_n), .start_i(start & geo), .probe_i(probe), .addr_i(addr),
    .busy_o(busy_l), .done_o(done_l), .rd_data_o(d_l), .rd_valid_o(v_l), .rd_ready_i(rdy),
    .nf_ce_n_o(ce_l), .nf_cle_o(cle_l), .nf_ale_o(ale_l), .nf_we_n_o(we_l), .nf_re_n_o(re_l),
    .nf_io_o(io_l), .nf_io_oe_o(oe_l), .nf_io_i(dq_l), .nf_rb_i(rb_l));

  nand_flash_model #(.LARGE(1'b1), .BUSY_CYC(BUSY)) flash_l_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .ce_n_i(ce_l), .cle_i(cle_l), .ale_i(ale_l),
    .we_n_i(we_l), .re_n_i(re_l), .oe_i(oe_l), .io_i(io_l), .rb_o(rb_l), .dq_o(dq_l),
    .cmd0_o(c0_l), .cmd1_o(c1_l), .ncmd_o(nc_l), .nadr_o(na_l), .err_o(er_l), .ab_o(ab_l));

  wire        v    = geo ? v_l : v_s;
  wire [7:0]  d    = geo ? d_l : d_s;
  wire        done = geo ? done_l : done_s;
  wire        busy = geo ? busy_l : busy_s;
  wire        ce_n = geo ? ce_l : ce_s;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion before it", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fdat(int pg, int cl);
    return 8'((pg * 13) + (cl * 3) + (cl >> 8));
  endfunction

  function automatic logic [7:0] exp_ab(bit lg, bit pr, logic [31:0] a, int i);
    if (!lg) begin
      case (i)
        0: return pr ? 8'h05 : a[7:0];
        1: return a[16:9];
        2: return a[24:17];
        default: return {1'b0, a[31:25]};
      endcase
    end
    case (i)
      0: return 8'h00;
      1: return pr ? 8'h08 : 8'h00;
      2: return a[18:11];
      3: return a[26:19];
      default: return {3'b000, a[31:27]};
    endcase
  endfunction

  function automatic logic rdy_pat(logic [1:0] bp, int it);
    case (bp)
      2'd0: return 1'b1;
      2'd1: return 1'(it % 2);
      default: return (it % 3) == 0;
    endcase
  endfunction

  task automatic run_op(bit lg, bit pr, logic [1:0] bp, logic [31:0] a, bit intr);
    int nexp, nb, mism, stallbad, it, pg, col0, nad;
    logic pend;
    logic [7:0] pend_d;
    string req;
    req  = lg ? (pr ? "R5" : "R4") : (pr ? "R3" : "R2");
    nexp = pr ? 1 : (lg ? 2048 : 512);
    pg   = lg ? int'(a >> 11) : int'(a >> 9);
    col0 = lg ? (pr ? 2048 : 0) : (pr ? 517 : int'(a[7:0]));
    nad  = lg ? 5 : 4;
    geo = lg; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; start = 1'b1; probe = pr; addr = a;
    @(negedge clk);
    start = 1'b0; probe = 1'b0; addr = '0;
    nb = 0; mism = 0; stallbad = 0; it = 0; pend = 1'b0; pend_d = '0;
    while (nb < nexp) begin
      @(negedge clk);
      it++;
      if (it == 2) chk("R12", "chip enable while busy", ce_n, 1'b0);
      if (intr && it == 15) begin start = 1'b1; probe = ~pr; addr = ~a; end
      else if (intr && it == 16) begin start = 1'b0; probe = 1'b0; addr = '0; end
      if (pend && (!v || d !== pend_d)) stallbad++;
      rdy = rdy_pat(bp, it);
      if (v && rdy) begin
        if (d !== fdat(pg, col0 + nb)) mism++;
        nb++;
        pend = 1'b0;
      end else begin
        pend = v; pend_d = d;
      end
    end
    @(negedge clk);
    chk("R10", "done after last accept", done, 1'b1);
    chk("R10", "busy low with done", busy, 1'b0);
    chk("R12", "chip enable after finish", ce_n, 1'b1);
    rdy = 1'b0;
    @(negedge clk);
    chk("R10", "done single cycle", done, 1'b0);
    chk("R7", "no byte after last", v, 1'b0);
    chk("R7", "data byte mismatches", mism, 0);
    chk("R8", "stalled byte changes", stallbad, 0);
    chk(req, "command count", lg ? nc_l : nc_s, lg ? 2 : 1);
    chk(req, "open command", lg ? c0_l : c0_s, (pr && !lg) ? 8'h50 : 8'h00);
    if (lg) chk(req, "confirm command", c1_l, 8'h30);
    chk(req, "address cycle count", lg ? na_l : na_s, nad);
    for (int k = 0; k < nad; k++)
      chk(req, "address byte", lg ? ab_l[8*k +: 8] : ab_s[8*k +: 8], exp_ab(lg, pr, a, k));
    chk("R6/R11", "flash protocol errors", lg ? er_l : er_s, 0);
    if (intr) begin
      chk("R9", "restart ignored: data", mism, 0);
      chk("R9", "restart ignored: address count", lg ? na_l : na_s, nad);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; probe = 1'b0; rdy = 1'b0; clr = 1'b0; geo = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    for (int pass = 0; pass < 2; pass++) begin
      chk("R1", "small ce_n", ce_s, 1'b1);   chk("R1", "large ce_n", ce_l, 1'b1);
      chk("R1", "small we_n", we_s, 1'b1);   chk("R1", "large we_n", we_l, 1'b1);
      chk("R1", "small re_n", re_s, 1'b1);   chk("R1", "large re_n", re_l, 1'b1);
      chk("R1", "small latches", {cle_s, ale_s, oe_s}, 3'b000);
      chk("R1", "large latches", {cle_l, ale_l, oe_l}, 3'b000);
      chk("R1", "small stream", {v_s, busy_s, done_s}, 3'b000);
      chk("R1", "large stream", {v_l, busy_l, done_l}, 3'b000);
      if (pass == 0) begin
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
      end
    end
    for (int i = 0; i < 8; i++)
      run_op(VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:0], 1'b0);
    // directed: restart attempts mid-operation
    run_op(1'b0, 1'b0, 2'd1, 32'h0002_4400, 1'b1);
    run_op(1'b1, 1'b1, 2'd0, 32'h0765_0800, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

endmodule